// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is an 18 Kb on-chip memory with two ports, A and B. Each port has its own clock, synchronous reset, enable, write enable, address, write data and registered read data, and either port may read or write at any time. Each port is given its own word width when the block is instantiated: 1, 2, 4, 9, 18 or 36 bits. The address width follows from that choice. Both ports work on one shared bit array, so a word written through a wide port can be read back as several narrow words through the other port, and the reverse also works.

The shared array is 512 rows of 36 bits. Bits 31..0 of a row hold data and bits 35..32 hold parity. The 9-, 18- and 36-bit widths carry 1, 2 and 4 parity bits as the top bits of their word. The 1-, 2- and 4-bit widths reach only the 16 Kb data portion.

Each port also has its own read-during-write behaviour, chosen by a parameter. A write can show the new word, show the old word, or leave the read register untouched.

Top module: `ratio_dpram`

## Requirements
- R1: A port of width W has data width D = W - W/9 (integer division, so D = W for W < 9) and addresses a word n at row n/(32/D), data bits starting at (n mod (32/D))*D of that row. Wider words therefore appear on a narrower port as consecutive addresses, least significant slice first. The address width is 9 + log2(32/D).
- R2: For W of 9, 18 or 36, the top W/9 bits of a word map to row bits 32 + (n mod (32/D))*(W/9) upward. A 1-, 2- or 4-bit port never changes parity bits.
- R3: In write-first mode (mode code 0), an enabled write loads the written word into the port's read register on the same clock edge.
- R4: In read-first mode (mode code 1), an enabled write loads the word the location held before that edge.
- R5: In no-change mode (mode code 2), an enabled write leaves the read register unchanged while the array is still updated.
- R6: With enable low, a port neither reads nor writes, whatever its write enable, and its read register holds its value.
- R7: Synchronous reset clears the port's read register to zero on the next edge, taking priority over enable, and leaves the array contents intact.
- R8: An enabled read with write enable low shows the addressed word one clock edge later. Writes by both ports in the same cycle to non-overlapping bits are both stored.
- R9: When both ports write overlapping bits in the same cycle, only those overlapped words are undefined. Every other word, including the rest of the same row, keeps its value.
- R10: A width outside the six supported values stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset of the read register |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | 9+log2(32/D_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset of the read register |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | 9+log2(32/D_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
Two pairs of functions can fall in the same cycle. The first is a read and a write on one port. The bench provokes it with writes on ports set to each of the three modes and compares the read register against the new word, the old word, or its previous value. The second is a write on each port landing in one row on the same edge. The bench issues such writes deliberately and flags the overlapped case as a collision without judging its data, then reads a neighbouring word of the same row to confirm it kept its value.

// File: rtl/ratio_dpram_pkg.sv
`timescale 1ns/1ps
package ratio_dpram_pkg;

   localparam int ROWS      = 512;
   localparam int ROW_AW    = $clog2(ROWS);
   localparam int DATA_BITS = 32;
   localparam int PAR_BITS  = 4;
   localparam int ROW_W     = DATA_BITS + PAR_BITS;

   typedef enum logic [1:0] {
      RDW_WRITE_FIRST = 2'd0,
      RDW_READ_FIRST  = 2'd1,
      RDW_NO_CHANGE   = 2'd2
   } rdw_mode_e;

   function automatic bit width_ok(int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int par_w(int w);
      return (w >= 9) ? (w / 9) : 0;
   endfunction

   function automatic int dat_w(int w);
      return w - par_w(w);
   endfunction

   function automatic int sub_bits(int w);
      return (dat_w(w) > 0) ? $clog2(DATA_BITS / dat_w(w)) : 0;
   endfunction

   function automatic int addr_w(int w);
      return ROW_AW + sub_bits(w);
   endfunction

endpackage

// File: rtl/ratio_dpram_lane.sv
`timescale 1ns/1ps
module ratio_dpram_lane
   import ratio_dpram_pkg::*;
#(
   parameter int W  = 36,
   parameter int AW = addr_w(W)
) (
   input  logic [AW-1:0]     addr,
   input  logic [W-1:0]      din,
   input  logic [ROW_W-1:0]  rowval,
   output logic [ROW_AW-1:0] row,
   output logic [ROW_W-1:0]  mask,
   output logic [ROW_W-1:0]  wval,
   output logic [W-1:0]      rword
);

   localparam int PW  = par_w(W);
   localparam int DW  = dat_w(W);
   localparam int SB  = sub_bits(W);
   localparam int SBX = (SB > 0) ? SB : 1;

   generate
      if (SB == 0) begin : g_full_row
         assign row   = addr[ROW_AW-1:0];
         assign mask  = '1;
         assign wval  = din;
         assign rword = rowval;
      end else begin : g_slice
         logic [SBX-1:0] sub;
         assign row = addr[AW-1:SB];
         assign sub = addr[SB-1:0];

         if (PW > 0) begin : g_with_par
            always_comb begin
               mask = '0;
               wval = '0;
               mask[int'(sub)*DW +: DW] = '1;
               wval[int'(sub)*DW +: DW] = din[DW-1:0];
               mask[DATA_BITS + int'(sub)*PW +: PW] = '1;
               wval[DATA_BITS + int'(sub)*PW +: PW] = din[W-1:DW];
            end
            always_comb begin
               rword[DW-1:0] = rowval[int'(sub)*DW +: DW];
               rword[W-1:DW] = rowval[DATA_BITS + int'(sub)*PW +: PW];
            end
         end else begin : g_data_only
            logic [DATA_BITS-1:0] dpart;
            logic                 unused_par;
            assign dpart      = rowval[DATA_BITS-1:0];
            assign unused_par = ^rowval[ROW_W-1:DATA_BITS];
            always_comb begin
               mask = '0;
               wval = '0;
               mask[int'(sub)*DW +: DW] = '1;
               wval[int'(sub)*DW +: DW] = din;
            end
            assign rword = dpart[int'(sub)*DW +: DW];
         end
      end
   endgenerate

endmodule

// File: rtl/ratio_dpram_store.sv
`timescale 1ns/1ps
module ratio_dpram_store
   import ratio_dpram_pkg::*;
(
   input  logic              clk_a,
   input  logic              wr_a,
   input  logic [ROW_AW-1:0] row_a,
   input  logic [ROW_W-1:0]  mask_a,
   input  logic [ROW_W-1:0]  wval_a,
   output logic [ROW_W-1:0]  rowval_a,
   input  logic              clk_b,
   input  logic              wr_b,
   input  logic [ROW_AW-1:0] row_b,
   input  logic [ROW_W-1:0]  mask_b,
   input  logic [ROW_W-1:0]  wval_b,
   output logic [ROW_W-1:0]  rowval_b
);

   // Each array has a single writer. Per bit, equal tags mean port A
   // wrote last and differing tags mean port B wrote last.
   logic [ROW_W-1:0] bank_a [ROWS];
   logic [ROW_W-1:0] bank_b [ROWS];
   logic [ROW_W-1:0] tag_a  [ROWS];
   logic [ROW_W-1:0] tag_b  [ROWS];

   always_ff @(posedge clk_a) begin
      if (wr_a) begin
         bank_a[row_a] <= (bank_a[row_a] & ~mask_a) | (wval_a & mask_a);
         tag_a[row_a]  <= (tag_a[row_a] & ~mask_a) | (tag_b[row_a] & mask_a);
      end
   end

   always_ff @(posedge clk_b) begin
      if (wr_b) begin
         bank_b[row_b] <= (bank_b[row_b] & ~mask_b) | (wval_b & mask_b);
         tag_b[row_b]  <= (tag_b[row_b] & ~mask_b) | (~tag_a[row_b] & mask_b);
      end
   end

   logic [ROW_W-1:0] from_b_a, from_b_b;
   assign from_b_a = tag_a[row_a] ^ tag_b[row_a];
   assign from_b_b = tag_a[row_b] ^ tag_b[row_b];

   assign rowval_a = (bank_a[row_a] & ~from_b_a) | (bank_b[row_a] & from_b_a);
   assign rowval_b = (bank_a[row_b] & ~from_b_b) | (bank_b[row_b] & from_b_b);

endmodule

// File: rtl/ratio_dpram_outreg.sv
`timescale 1ns/1ps
module ratio_dpram_outreg
   import ratio_dpram_pkg::*;
#(
   parameter int        W    = 36,
   parameter rdw_mode_e MODE = RDW_WRITE_FIRST
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         we,
   input  logic [W-1:0] din,
   input  logic [W-1:0] rword,
   output logic [W-1:0] dout
);

   generate
      if (MODE == RDW_WRITE_FIRST) begin : g_wf
         always_ff @(posedge clk) begin
            if (rst)     dout <= '0;
            else if (en) dout <= we ? din : rword;
         end
      end else if (MODE == RDW_READ_FIRST) begin : g_rf
         logic unused_din;
         assign unused_din = ^{din, we};
         always_ff @(posedge clk) begin
            if (rst)     dout <= '0;
            else if (en) dout <= rword;
         end
      end else begin : g_nc
         logic unused_din;
         assign unused_din = ^din;
         always_ff @(posedge clk) begin
            if (rst)            dout <= '0;
            else if (en && !we) dout <= rword;
         end
      end
   endgenerate

endmodule

// File: rtl/ratio_dpram.sv
`timescale 1ns/1ps
module ratio_dpram
   import ratio_dpram_pkg::*;
#(
   parameter int        WIDTH_A = 36,
   parameter int        WIDTH_B = 9,
   parameter rdw_mode_e MODE_A  = RDW_WRITE_FIRST,
   parameter rdw_mode_e MODE_B  = RDW_READ_FIRST,
   parameter int        AW_A    = addr_w(WIDTH_A),
   parameter int        AW_B    = addr_w(WIDTH_B)
) (
   input  logic               clk_a,
   input  logic               rst_a,
   input  logic               en_a,
   input  logic               we_a,
   input  logic [AW_A-1:0]    addr_a,
   input  logic [WIDTH_A-1:0] din_a,
   output logic [WIDTH_A-1:0] dout_a,
   input  logic               clk_b,
   input  logic               rst_b,
   input  logic               en_b,
   input  logic               we_b,
   input  logic [AW_B-1:0]    addr_b,
   input  logic [WIDTH_B-1:0] din_b,
   output logic [WIDTH_B-1:0] dout_b
);

   // R10: elaboration-time parameter checks
   generate
      if (!width_ok(WIDTH_A)) begin : g_bad_width_a
         $error("ratio_dpram: WIDTH_A must be 1, 2, 4, 9, 18 or 36");
      end
      if (!width_ok(WIDTH_B)) begin : g_bad_width_b
         $error("ratio_dpram: WIDTH_B must be 1, 2, 4, 9, 18 or 36");
      end
      if (AW_A != addr_w(WIDTH_A) || AW_B != addr_w(WIDTH_B)) begin : g_bad_aw
         $error("ratio_dpram: address widths must follow the port widths");
      end
   endgenerate

   logic [ROW_AW-1:0] row_a, row_b;
   logic [ROW_W-1:0]  mask_a, mask_b, wval_a, wval_b, rowval_a, rowval_b;
   logic [WIDTH_A-1:0] rword_a;
   logic [WIDTH_B-1:0] rword_b;

   ratio_dpram_lane #(.W(WIDTH_A), .AW(AW_A)) u_lane_a (
      .addr(addr_a), .din(din_a), .rowval(rowval_a),
      .row(row_a), .mask(mask_a), .wval(wval_a), .rword(rword_a)
   );

   ratio_dpram_lane #(.W(WIDTH_B), .AW(AW_B)) u_lane_b (
      .addr(addr_b), .din(din_b), .rowval(rowval_b),
      .row(row_b), .mask(mask_b), .wval(wval_b), .rword(rword_b)
   );

   ratio_dpram_store u_store (
      .clk_a(clk_a), .wr_a(en_a & we_a), .row_a(row_a), .mask_a(mask_a),
      .wval_a(wval_a), .rowval_a(rowval_a),
      .clk_b(clk_b), .wr_b(en_b & we_b), .row_b(row_b), .mask_b(mask_b),
      .wval_b(wval_b), .rowval_b(rowval_b)
   );

   ratio_dpram_outreg #(.W(WIDTH_A), .MODE(MODE_A)) u_out_a (
      .clk(clk_a), .rst(rst_a), .en(en_a), .we(we_a),
      .din(din_a), .rword(rword_a), .dout(dout_a)
   );

   ratio_dpram_outreg #(.W(WIDTH_B), .MODE(MODE_B)) u_out_b (
      .clk(clk_b), .rst(rst_b), .en(en_b), .we(we_b),
      .din(din_b), .rword(rword_b), .dout(dout_b)
   );

endmodule

// File: rtl/ratio_dpram_chk.sv
`timescale 1ns/1ps
module ratio_dpram_chk
   import ratio_dpram_pkg::*;
#(
   parameter int        WIDTH_A = 36,
   parameter int        WIDTH_B = 9,
   parameter rdw_mode_e MODE_A  = RDW_WRITE_FIRST,
   parameter rdw_mode_e MODE_B  = RDW_READ_FIRST
) (
   input logic               clk_a,
   input logic               rst_a,
   input logic               en_a,
   input logic               we_a,
   input logic [WIDTH_A-1:0] din_a,
   input logic [WIDTH_A-1:0] dout_a,
   input logic               clk_b,
   input logic               rst_b,
   input logic               en_b,
   input logic               we_b,
   input logic [WIDTH_B-1:0] din_b,
   input logic [WIDTH_B-1:0] dout_b
);

   logic unused_chk;
   assign unused_chk = ^{din_a, din_b};

   assert_idle_hold_a_R6: assert property (@(posedge clk_a) disable iff (rst_a)
      !en_a |=> $stable(dout_a))
      else $error("R6 port A read register moved while disabled");

   assert_idle_hold_b_R6: assert property (@(posedge clk_b) disable iff (rst_b)
      !en_b |=> $stable(dout_b))
      else $error("R6 port B read register moved while disabled");

   assert_reset_clear_a_R7: assert property (@(posedge clk_a)
      rst_a |=> (dout_a == '0))
      else $error("R7 port A read register not cleared by reset");

   assert_reset_clear_b_R7: assert property (@(posedge clk_b)
      rst_b |=> (dout_b == '0))
      else $error("R7 port B read register not cleared by reset");

   generate
      if (MODE_A == RDW_WRITE_FIRST) begin : g_wf_a
         assert_write_first_a_R3: assert property (@(posedge clk_a) disable iff (rst_a)
            (en_a && we_a) |=> (dout_a == $past(din_a)))
            else $error("R3 port A write-first did not show new word");
      end else if (MODE_A == RDW_NO_CHANGE) begin : g_nc_a
         assert_no_change_a_R5: assert property (@(posedge clk_a) disable iff (rst_a)
            (en_a && we_a) |=> $stable(dout_a))
            else $error("R5 port A no-change register moved on write");
      end
      if (MODE_B == RDW_WRITE_FIRST) begin : g_wf_b
         assert_write_first_b_R3: assert property (@(posedge clk_b) disable iff (rst_b)
            (en_b && we_b) |=> (dout_b == $past(din_b)))
            else $error("R3 port B write-first did not show new word");
      end else if (MODE_B == RDW_NO_CHANGE) begin : g_nc_b
         assert_no_change_b_R5: assert property (@(posedge clk_b) disable iff (rst_b)
            (en_b && we_b) |=> $stable(dout_b))
            else $error("R5 port B no-change register moved on write");
      end
   endgenerate

endmodule

bind ratio_dpram ratio_dpram_chk #(
   .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
   .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .din_a(din_a), .dout_a(dout_a),
   .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/sim_ratio_dpram.sv
`timescale 1ns/1ps
module sim_ratio_dpram;
   import ratio_dpram_pkg::*;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   int n_chk  = 0;
   int n_fail = 0;

   // Instance u0: A = 36 bits write-first, B = 9 bits read-first
   logic        en_a0, we_a0, en_b0, we_b0;
   logic [8:0]  addr_a0;
   logic [10:0] addr_b0;
   logic [35:0] din_a0, dout_a0;
   logic [8:0]  din_b0, dout_b0;

   ratio_dpram #(.WIDTH_A(36), .WIDTH_B(9),
                 .MODE_A(RDW_WRITE_FIRST), .MODE_B(RDW_READ_FIRST)) u0 (
      .clk_a(clk), .rst_a(rst), .en_a(en_a0), .we_a(we_a0), .addr_a(addr_a0),
      .din_a(din_a0), .dout_a(dout_a0),
      .clk_b(clk), .rst_b(rst), .en_b(en_b0), .we_b(we_b0), .addr_b(addr_b0),
      .din_b(din_b0), .dout_b(dout_b0)
   );

   // Instance u1: A = 1 bit no-change, B = 18 bits write-first
   logic        en_a1, we_a1, en_b1, we_b1;
   logic [13:0] addr_a1;
   logic [9:0]  addr_b1;
   logic [0:0]  din_a1, dout_a1;
   logic [17:0] din_b1, dout_b1;

   ratio_dpram #(.WIDTH_A(1), .WIDTH_B(18),
                 .MODE_A(RDW_NO_CHANGE), .MODE_B(RDW_WRITE_FIRST)) u1 (
      .clk_a(clk), .rst_a(rst), .en_a(en_a1), .we_a(we_a1), .addr_a(addr_a1),
      .din_a(din_a1), .dout_a(dout_a1),
      .clk_b(clk), .rst_b(rst), .en_b(en_b1), .we_b(we_b1), .addr_b(addr_b1),
      .din_b(din_b1), .dout_b(dout_b1)
   );

   typedef struct packed {
      logic        on_b;
      logic        we;
      logic [13:0] addr;
      logic [35:0] data;
      logic [35:0] expect_q;
   } vec_t;

   // Port A (36) writes a word, port B (9) slices it; parity bits ride on top.
   localparam vec_t VEC [0:10] = '{
      '{1'b0, 1'b1, 14'd5,    36'h9_8765_4321, 36'h9_8765_4321}, // R3 write-first
      '{1'b1, 1'b0, 14'd20,   36'h0,           36'h121},         // R1 R2 slice 0
      '{1'b1, 1'b0, 14'd21,   36'h0,           36'h043},
      '{1'b1, 1'b0, 14'd22,   36'h0,           36'h065},
      '{1'b1, 1'b0, 14'd23,   36'h0,           36'h187},
      '{1'b1, 1'b1, 14'd22,   36'h1AA,         36'h065},         // R4 read-first
      '{1'b0, 1'b0, 14'd5,    36'h0,           36'hD_87AA_4321}, // R1 R2 merge
      '{1'b1, 1'b0, 14'd22,   36'h0,           36'h1AA},
      '{1'b0, 1'b1, 14'd511,  36'hF_0000_FFFF, 36'hF_0000_FFFF},
      '{1'b1, 1'b0, 14'd2047, 36'h0,           36'h100},         // top address
      '{1'b1, 1'b0, 14'd2044, 36'h0,           36'h1FF}
   };

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp_v);
      end
   endtask

   task automatic idle();
      en_a0 = 0; we_a0 = 0; en_b0 = 0; we_b0 = 0;
      en_a1 = 0; we_a1 = 0; en_b1 = 0; we_b1 = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      idle();
      addr_a0 = '0; addr_b0 = '0; din_a0 = '0; din_b0 = '0;
      addr_a1 = '0; addr_b1 = '0; din_a1 = '0; din_b1 = '0;
      rst = 1'b1;
      repeat (3) tick();
      check("R7 reset u0 port A", dout_a0, 36'h0);
      check("R7 reset u0 port B", {27'h0, dout_b0}, 36'h0);
      check("R7 reset u1 port B", {18'h0, dout_b1}, 36'h0);
      rst = 1'b0;

      // ---- table walk on u0 (R1 R2 R3 R4 R8) ----
      for (int i = 0; i < 11; i++) begin
         idle();
         if (VEC[i].on_b) begin
            en_b0 = 1; we_b0 = VEC[i].we;
            addr_b0 = VEC[i].addr[10:0]; din_b0 = VEC[i].data[8:0];
         end else begin
            en_a0 = 1; we_a0 = VEC[i].we;
            addr_a0 = VEC[i].addr[8:0]; din_a0 = VEC[i].data;
         end
         tick();
         check($sformatf("R1 R8 table entry %0d", i),
               VEC[i].on_b ? {27'h0, dout_b0} : dout_a0, VEC[i].expect_q);
      end

      // ---- R6: disabled write on port B has no effect ----
      idle();
      we_b0 = 1; addr_b0 = 11'd22; din_b0 = 9'h000;
      tick();
      check("R6 disabled port holds", {27'h0, dout_b0}, 36'h1FF);
      idle();
      en_b0 = 1; addr_b0 = 11'd22;
      tick();
      check("R6 disabled write ignored", {27'h0, dout_b0}, 36'h1AA);

      // ---- R8: simultaneous writes to different rows ----
      idle();
      en_a0 = 1; we_a0 = 1; addr_a0 = 9'd10; din_a0 = 36'h1_2345_6789;
      en_b0 = 1; we_b0 = 1; addr_b0 = 11'd1201; din_b0 = 9'h0F0;
      tick();
      check("R3 port A during dual write", dout_a0, 36'h1_2345_6789);
      idle();
      en_b0 = 1; addr_b0 = 11'd41;
      tick();
      check("R8 port A word seen by B", {27'h0, dout_b0}, 36'h067);
      idle();
      en_b0 = 1; addr_b0 = 11'd1201;
      tick();
      check("R8 port B word stored", {27'h0, dout_b0}, 36'h0F0);

      // ---- R7: reset beats enable, memory survives ----
      idle();
      rst = 1; en_a0 = 1; addr_a0 = 9'd5;
      tick();
      rst = 0;
      check("R7 reset priority over read", dout_a0, 36'h0);
      idle();
      en_a0 = 1; addr_a0 = 9'd5;
      tick();
      check("R7 contents kept through reset", dout_a0, 36'hD_87AA_4321);

      // ---- u1: narrow no-change port against 18-bit write-first ----
      idle();
      en_b1 = 1; we_b1 = 1; addr_b1 = 10'd3; din_b1 = 18'h2_BEEF;
      tick();
      check("R3 u1 B write-first", {18'h0, dout_b1}, 36'h2_BEEF);
      idle();
      en_a1 = 1; addr_a1 = 14'd48;
      tick();
      check("R1 u1 bit 48", {35'h0, dout_a1}, 36'h1);
      idle();
      en_a1 = 1; addr_a1 = 14'd60;
      tick();
      check("R1 u1 bit 60", {35'h0, dout_a1}, 36'h1);
      idle();
      en_a1 = 1; addr_a1 = 14'd52;
      tick();
      check("R1 u1 bit 52", {35'h0, dout_a1}, 36'h0);
      idle();
      en_a1 = 1; we_a1 = 1; addr_a1 = 14'd52; din_a1 = 1'b1;
      tick();
      check("R5 no-change keeps register", {35'h0, dout_a1}, 36'h0);
      idle();
      en_a1 = 1; addr_a1 = 14'd52;
      tick();
      check("R5 no-change write landed", {35'h0, dout_a1}, 36'h1);
      idle();
      en_b1 = 1; addr_b1 = 10'd3;
      tick();
      check("R2 narrow write keeps parity", {18'h0, dout_b1}, 36'h2_BEFF);

      idle();
      we_a1 = 1; addr_a1 = 14'd52; din_a1 = 1'b0;
      tick();
      check("R6 u1 disabled A holds", {35'h0, dout_a1}, 36'h1);
      idle();
      en_a1 = 1; addr_a1 = 14'd52;
      tick();
      check("R6 u1 disabled write ignored", {35'h0, dout_a1}, 36'h1);

      // ---- R9: overlapping writes, neighbour in same row survives ----
      idle();
      en_b1 = 1; we_b1 = 1; addr_b1 = 10'd5; din_b1 = 18'h1_2345;
      tick();
      idle();
      en_a1 = 1; we_a1 = 1; addr_a1 = 14'd64; din_a1 = 1'b1;
      en_b1 = 1; we_b1 = 1; addr_b1 = 10'd4; din_b1 = 18'h0_0000;
      if ((addr_a1 / 32) == (addr_b1 / 2) && ((addr_a1 % 32) / 16) == (addr_b1 % 2))
         $display("note: R9 collision flagged at row %0d, data not judged", addr_a1 / 32);
      tick();
      idle();
      en_b1 = 1; addr_b1 = 10'd5;
      tick();
      check("R9 neighbour word intact", {18'h0, dout_b1}, 36'h1_2345);

      idle();
      tick();
      report();
      $finish;
   end

endmodule